// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits in a keyboard/pointer host controller and decides what the host sees when one or both serial devices have a byte ready. It takes a data-available level from the keyboard source and from the auxiliary (pointer) source. From these and the controller's mode byte it drives the output-buffer-full flags, the auxiliary-buffer-full flags and the two interrupt lines. It also chooses which source answers a read of the data port.

The keyboard source always wins. The auxiliary source is seen only when it is the only one with data. Each interrupt line has its own enable bits in the mode byte. All flags and interrupt levels are registered, so they follow their inputs one clock later. A mode-byte change, including the keyboard enable and disable commands, therefore shows up on the next clock without any change in the pending levels. A data-port read returns the selected source's byte and pulses a pop strobe towards that source, so the source can lower its level. The byte queues themselves live outside the block.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset, every flag, both interrupt lines and both pop strobes are low, and a data-port read returns the keyboard byte.
- R2: One clock after either pending level is high, the status and output-port buffer-full flags are both 1. One clock after both pending levels are low, both flags are 0.
- R3: The status and output-port auxiliary-full flags are 1 one clock after the auxiliary level is high while the keyboard level is low. In every other case they are 0.
- R4: While keyboard data is pending, the keyboard interrupt is high one clock later only if mode bit 0 is 1 and mode bit 4 is 0. Otherwise it is low.
- R5: While keyboard data is pending, the auxiliary interrupt is low one clock later, even if auxiliary data is also pending and mode bit 1 is 1.
- R6: While only auxiliary data is pending, the auxiliary interrupt is high one clock later if and only if mode bit 1 is 1, and the keyboard interrupt is low.
- R7: A data-port read returns the auxiliary byte only when the previous clock saw auxiliary data as the sole pending source. Otherwise it returns the keyboard byte.
- R8: While the read strobe is high, exactly one pop strobe is high: the auxiliary pop in the R7 auxiliary case, and the keyboard pop otherwise. Both pops are low without a read.
- R9: A change of the mode byte alone, with the pending levels held, updates the interrupt lines on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kbdPending | input | 1 | Keyboard source has data |
| auxPending | input | 1 | Auxiliary source has data |
| modeReg | input | MODE_W | Controller mode byte (bit 0 keyboard interrupt enable, bit 1 auxiliary interrupt enable, bit 4 keyboard disable) |
| kbdByte | input | DATA_W | Head byte of keyboard source |
| auxByte | input | DATA_W | Head byte of auxiliary source |
| dataRead | input | 1 | Data-port read strobe |
| statusObf | output | 1 | Status bit 0: output buffer full |
| statusAuxObf | output | 1 | Status bit 5: auxiliary data in buffer |
| portObf | output | 1 | Output port bit 4: buffer full |
| portAuxObf | output | 1 | Output port bit 5: auxiliary buffer full |
| irqKbd | output | 1 | Keyboard interrupt level |
| irqAux | output | 1 | Auxiliary interrupt level |
| readData | output | DATA_W | Byte returned by a data-port read |
| kbdPop | output | 1 | Pop strobe to keyboard source |
| auxPop | output | 1 | Pop strobe to auxiliary source |

## Verification
The hardest case is having both sources pending with every interrupt enable set. It must show that the keyboard takes the interrupt, the flags and the read path while the auxiliary interrupt stays low. The stimulus reaches it by raising the auxiliary level first, confirming the auxiliary-only state, and then raising the keyboard level on top of it. Reads are issued only after the pending levels have been steady for a clock, so the registered source choice is settled. The bench then lowers the keyboard level to show the auxiliary path taking over, and toggles only mode bit 4 to show the interrupt re-evaluated with no pending change.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;
  localparam int MODE_KBD_IRQ_EN = 0;
  localparam int MODE_AUX_IRQ_EN = 1;
  localparam int MODE_KBD_OFF    = 4;

  typedef struct packed {
    logic anyFull;
    logic auxOnly;
    logic kbdIrq;
    logic auxIrq;
  } arbStrobes_t;
endpackage

// File: rtl/obuf_arb_ctrl.sv
module obuf_arb_ctrl
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              kbdPending,
  input  logic              auxPending,
  input  logic [MODE_W-1:0] modeReg,
  output arbStrobes_t       strobes
);
  logic kbdIrqOk;
  logic auxIrqOk;

  always_comb begin
    kbdIrqOk = modeReg[MODE_KBD_IRQ_EN] && !modeReg[MODE_KBD_OFF];
    auxIrqOk = modeReg[MODE_AUX_IRQ_EN];
    strobes.anyFull = kbdPending || auxPending;
    strobes.auxOnly = auxPending && !kbdPending;
    // keyboard wins: its interrupt path is taken whenever it has data
    strobes.kbdIrq  = kbdPending && kbdIrqOk;
    strobes.auxIrq  = strobes.auxOnly && auxIrqOk;
  end
endmodule

// File: rtl/obuf_arb_dpath.sv
module obuf_arb_dpath
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobes_t       strobes,
  input  logic              dataRead,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] auxByte,
  output logic              obfFlag,
  output logic              auxObfFlag,
  output logic              irqKbd,
  output logic              irqAux,
  output logic [DATA_W-1:0] readData,
  output logic              kbdPop,
  output logic              auxPop
);
  arbStrobes_t held;

  always_ff @(posedge clk) begin
    if (!rstN) held <= '0;
    else       held <= strobes;
  end

  always_comb begin
    obfFlag    = held.anyFull;
    auxObfFlag = held.auxOnly;
    irqKbd     = held.kbdIrq;
    irqAux     = held.auxIrq;
    readData   = held.auxOnly ? auxByte : kbdByte;
    kbdPop     = dataRead && !held.auxOnly;
    auxPop     = dataRead && held.auxOnly;
  end

  assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({irqKbd, irqAux}));
  assert_aux_implies_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    auxObfFlag |-> obfFlag);
  assert_pop_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({kbdPop, auxPop}));
  assert_read_pops_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataRead |-> (kbdPop || auxPop));
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdPending,
  input  logic              auxPending,
  input  logic [MODE_W-1:0] modeReg,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] auxByte,
  input  logic              dataRead,
  output logic              statusObf,
  output logic              statusAuxObf,
  output logic              portObf,
  output logic              portAuxObf,
  output logic              irqKbd,
  output logic              irqAux,
  output logic [DATA_W-1:0] readData,
  output logic              kbdPop,
  output logic              auxPop
);
  arbStrobes_t strobes;
  logic obfFlag;
  logic auxObfFlag;

  obuf_arb_ctrl #(.MODE_W(MODE_W)) u_ctrl (
    .kbdPending(kbdPending),
    .auxPending(auxPending),
    .modeReg(modeReg),
    .strobes(strobes)
  );

  obuf_arb_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .dataRead(dataRead),
    .kbdByte(kbdByte),
    .auxByte(auxByte),
    .obfFlag(obfFlag),
    .auxObfFlag(auxObfFlag),
    .irqKbd(irqKbd),
    .irqAux(irqAux),
    .readData(readData),
    .kbdPop(kbdPop),
    .auxPop(auxPop)
  );

  assign statusObf    = obfFlag;
  assign portObf      = obfFlag;
  assign statusAuxObf = auxObfFlag;
  assign portAuxObf   = auxObfFlag;

  assert_full_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (kbdPending || auxPending) |=> (statusObf && portObf));
  assert_empty_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!kbdPending && !auxPending) |=> (!statusObf && !portObf));
  assert_kbd_blocks_aux_R5: assert property (@(posedge clk) disable iff (!rstN)
    kbdPending |=> (!irqAux && !statusAuxObf));
  assert_kbd_irq_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (kbdPending && modeReg[MODE_KBD_IRQ_EN] && !modeReg[MODE_KBD_OFF]) |=> irqKbd);
  assert_kbd_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeReg[MODE_KBD_OFF] |=> !irqKbd);
  assert_aux_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (auxPending && !kbdPending && modeReg[MODE_AUX_IRQ_EN]) |=> (irqAux && !irqKbd));
endmodule

// File: tb/sim_obuf_arbiter.sv
module sim_obuf_arbiter;
  logic clk = 0;
  logic rstN = 0;
  logic kbdPending = 0, auxPending = 0, dataRead = 0;
  logic [7:0] modeReg = 8'h03, kbdByte = 8'h00, auxByte = 8'h00;
  logic statusObf, statusAuxObf, portObf, portAuxObf, irqKbd, irqAux, kbdPop, auxPop;
  logic [7:0] readData;

  always #4 clk = ~clk;

  obuf_arbiter u0 (.*);

  typedef struct {
    logic [14:0] val;
    string tag;
  } expItem_t;

  expItem_t scq[$];
  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  function automatic logic [14:0] actual();
    return {statusObf, portObf, statusAuxObf, portAuxObf, irqKbd, irqAux,
            kbdPop, auxPop, readData[6:0]};
  endfunction

  task automatic drive(input logic kp, input logic ap, input logic [7:0] md,
                       input logic rd, input string tag);
    logic aOnly;
    logic [7:0] rbyte;
    expItem_t it;
    @(negedge clk);
    kbdPending = kp; auxPending = ap; modeReg = md; dataRead = rd;
    kbdByte = $urandom_range(0, 255); auxByte = kbdByte ^ 8'h5A;
    aOnly = ap && !kp;
    rbyte = aOnly ? auxByte : kbdByte;
    it.val = {kp || ap, kp || ap, aOnly, aOnly,
              kp && md[0] && !md[4], aOnly && md[1],
              rd && !aOnly, rd && aOnly, rbyte[6:0]};
    it.tag = tag;
    scq.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (scq.size() > 0) begin
        expItem_t e;
        e = scq.pop_front();
        tests++;
        if (actual() !== e.val) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", e.tag, actual(), e.val);
        end
      end
    end
  end

  initial begin : watchdog
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if ({statusObf, portObf, statusAuxObf, portAuxObf, irqKbd, irqAux, kbdPop, auxPop} !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset actual=%b expected=0", {statusObf, statusAuxObf, irqKbd, irqAux});
    end
    @(negedge clk); rstN = 1;
    drive(0, 0, 8'h03, 0, "R1 idle after reset");
    drive(0, 0, 8'h03, 1, "R1 read empty returns keyboard");
    drive(1, 0, 8'h03, 0, "R2 R4 keyboard pending irq");
    drive(1, 0, 8'h03, 1, "R7 R8 keyboard read and pop");
    drive(1, 0, 8'h13, 0, "R9 R4 keyboard disabled via mode");
    drive(1, 0, 8'h03, 0, "R9 keyboard re-enabled via mode");
    drive(1, 0, 8'h02, 0, "R4 keyboard irq enable clear");
    drive(0, 0, 8'h03, 0, "R2 cleared when empty");
    drive(0, 1, 8'h03, 0, "R3 R6 aux only irq");
    drive(0, 1, 8'h03, 1, "R7 R8 aux read and pop");
    drive(0, 1, 8'h01, 0, "R6 aux irq enable clear");
    drive(0, 1, 8'h13, 0, "R6 aux irq unaffected by kbd disable");
    drive(1, 1, 8'h03, 0, "R5 both pending keyboard wins");
    drive(1, 1, 8'h03, 1, "R5 R7 R8 both pending read keyboard");
    drive(1, 1, 8'h12, 0, "R5 both pending kbd gated aux still low");
    drive(0, 1, 8'h03, 0, "R3 aux takes over");
    drive(0, 1, 8'h03, 1, "R8 aux pop after takeover");
    drive(0, 0, 8'h03, 0, "R2 R8 empty no pops");
    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule